// File: doc/BRIEF.md
# Nine-Bit Serial Command and Parameter Link

This block is the controller side of a three-wire serial link to a display controller. Every frame it sends is nine bits long. The first bit tells the receiver how to treat the remaining eight: a 0 marks a command byte and a 1 marks a parameter byte. The byte follows most significant bit first. The serial clock idles low. The block changes its output data after each falling edge, and the far end samples on the rising edge. The rate of the serial clock comes from a parameterised divider of the system clock.

A register read uses the same shared data line. The block first sends a command frame, then releases the line and clocks in one nine-bit word for each requested byte, all under one chip-select assertion. The far end inserts a dummy clock, so the words arrive shifted. The block realigns each word into a byte before it returns the result with a one-cycle done pulse. An upstream agent hands requests over through a valid/ready handshake. If the next write request is already waiting while the last bit of a write frame is on the wire, that write continues under the same chip select.

Top module: `nine_bit_spi_link`

## Requirements
- R1: Out of reset, cs_n is 1, sclk is 0, sda_oe is 0, busy is 0, req_ready is 1, rd_done and rd_err are 0, and rd_data is 0.
- R2: A write frame puts 9 bits on sda_out on nine rising edges of sclk. Bit 1 is 0 for a command (req_is_data=0) or 1 for a parameter (req_is_data=1). Bits 2 to 9 carry req_byte, MSB first. sda_out holds steady while sclk is high.
- R3: cs_n falls HALF_DIV system clocks before the first rising edge of sclk. It rises HALF_DIV clocks after the final falling edge of sclk, and sclk is low at both chip-select edges.
- R4: Inside a transaction, successive rising edges of sclk are exactly 2*HALF_DIV system clocks apart, including across chained frames and the receive phase.
- R5: busy is 1 from the cycle after a request is accepted until the cycle in which cs_n returns to 1.
- R6: A write request (req_read=0) presented while the last bit of a write frame is high is accepted in that frame's final high cycle. Its 9 bits follow without cs_n deasserting.
- R7: A read (req_read=1) sends one command frame with flag bit 0, whatever the value of req_is_data. After the falling edge that ends the command frame, sda_oe drops to 0 and the block gives req_rlen*9 further rising edges of sclk under the same chip select.
- R8: A read with req_rlen other than 1, 3 or 4 is accepted and answered by a one-cycle rd_err pulse. cs_n does not fall, and rd_data keeps its value.
- R9: Received word i (9 bits, MSB first, index i from 0) yields byte i = low 8 bits of ((word_i >> i) | (carry << (9-i))). carry is 0 for i = 0 and 1. For i >= 2, carry is word_(i-1) masked to its low (i-1) bits. Byte i is placed in rd_data[8i+7:8i], and a read clears rd_data when it is accepted.
- R10: rd_done pulses for one cycle, in the cycle where cs_n returns to 1 after a read, and never together with rd_err. An identification read of 3 bytes returns 0x85, 0x85, 0x52 when the far end sends the matching words.
- R11: A read request is never taken into the chaining window. It is accepted only once cs_n is back at 1, and it starts its own chip-select assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken when high with req_valid |
| req_read | input | 1 | 1 = register read, 0 = write frame |
| req_is_data | input | 1 | Write frame flag: 1 parameter, 0 command |
| req_byte | input | 8 | Payload byte, or command byte of a read |
| req_rlen | input | 3 | Number of bytes to read (1, 3 or 4) |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| sda_out | output | 1 | Serial data toward the display |
| sda_oe | output | 1 | Drive enable for the shared data line |
| sda_in | input | 1 | Serial data from the display |
| busy | output | 1 | Transaction in progress |
| rd_done | output | 1 | One-cycle read completion pulse |
| rd_err | output | 1 | One-cycle pulse for an unsupported read length |
| rd_data | output | 32 | Realigned read bytes, byte 0 lowest |

## Verification
The bench builds the block with HALF_DIV = 3. This odd divider tests the half-period counter away from the power-of-two case, and a frame still takes only 54 system clocks. The bench measures every chip-select edge and every sclk period in system clocks against that divider. It drives the return words so that all three carry cases of the realignment show up in reads of 1, 3 and 4 bytes. It also places a write and a read against the chaining window.

// File: rtl/nine_bit_spi_link.sv
`timescale 1ns/1ps
module nine_bit_spi_link #(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_read,
  input  logic        req_is_data,
  input  logic [7:0]  req_byte,
  input  logic [2:0]  req_rlen,
  output logic        sclk,
  output logic        cs_n,
  output logic        sda_out,
  output logic        sda_oe,
  input  logic        sda_in,
  output logic        busy,
  output logic        rd_done,
  output logic        rd_err,
  output logic [31:0] rd_data
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_HIGH, S_LOW} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [8:0]   txsh;
  logic [3:0]   txleft;
  logic [5:0]   rxleft;
  logic [3:0]   rxbit;
  logic [7:0]   w;
  logic [1:0]   idx;
  logic [2:0]   carry;
  logic         rx_on, is_rd, fin;

  wire tick    = (cnt == CW'(HALF_DIV - 1));
  wire len_ok  = (req_rlen == 3'd1) || (req_rlen == 3'd3) || (req_rlen == 3'd4);
  wire last_tx = (st == S_HIGH) && tick && !rx_on && (txleft == 4'd1);

  assign req_ready = (st == S_IDLE) || (last_tx && !is_rd && !req_read);
  assign sclk      = (st == S_HIGH);
  assign cs_n      = (st == S_IDLE);
  assign busy      = (st != S_IDLE);
  assign sda_oe    = (st != S_IDLE) && !rx_on;
  assign sda_out   = txsh[8];

  wire  [8:0]  wn = {w, sda_in};
  logic [17:0] al;
  logic [2:0]  carry_nx;
  always_comb begin
    al       = ({9'b0, wn} >> idx) | ({15'b0, carry} << (4'd9 - {2'b0, idx}));
    carry_nx = wn[2:0] & ((3'd1 << idx) - 3'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; txsh <= '0; txleft <= '0; rxleft <= '0;
      rxbit <= '0; w <= '0; idx <= '0; carry <= '0;
      rx_on <= 1'b0; is_rd <= 1'b0; fin <= 1'b0;
      rd_done <= 1'b0; rd_err <= 1'b0; rd_data <= '0;
    end else begin
      rd_done <= 1'b0;
      rd_err  <= 1'b0;
      if (st == S_IDLE || tick) cnt <= '0;
      else                      cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          if (req_read && !len_ok) rd_err <= 1'b1;
          else begin
            st     <= S_SETUP;
            txsh   <= {req_read ? 1'b0 : req_is_data, req_byte};
            txleft <= 4'd9;
            is_rd  <= req_read;
            rx_on  <= 1'b0;
            fin    <= 1'b0;
            rxleft <= 6'(req_rlen) * 6'd9;
            rxbit  <= '0;
            w      <= '0;
            idx    <= '0;
            carry  <= '0;
            if (req_read) rd_data <= '0;
          end
        end
        S_SETUP: if (tick) st <= S_HIGH;
        S_HIGH: if (tick) begin
          st <= S_LOW;
          if (!rx_on) begin
            if (txleft == 4'd1) begin
              if (is_rd) rx_on <= 1'b1;
              else if (req_valid && req_ready) begin
                txsh   <= {req_is_data, req_byte};
                txleft <= 4'd9;
              end else fin <= 1'b1;
            end else begin
              txsh   <= {txsh[7:0], 1'b0};
              txleft <= txleft - 4'd1;
            end
          end else begin
            rxleft <= rxleft - 6'd1;
            if (rxbit == 4'd8) begin
              rxbit <= '0;
              w     <= '0;
              rd_data[{idx, 3'b000} +: 8] <= al[7:0];
              idx   <= idx + 2'd1;
              carry <= carry_nx;
            end else begin
              rxbit <= rxbit + 4'd1;
              w     <= {w[6:0], sda_in};
            end
            if (rxleft == 6'd1) fin <= 1'b1;
          end
        end
        S_LOW: if (tick) begin
          if (fin) begin
            st      <= S_IDLE;
            rd_done <= is_rd;
          end else st <= S_HIGH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module nine_bit_spi_link_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_read,
  input logic        sclk,
  input logic        cs_n,
  input logic        sda_out,
  input logic        sda_oe,
  input logic        rd_done,
  input logic        rd_err
);
  // R10
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_done && rd_err));
  // R8
  err_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (cs_n && $past(cs_n)));
  // R3
  cs_fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sclk);
  // R3
  cs_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !$past(sclk));
  // R2
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk) && sda_oe && $past(sda_oe)) |-> $stable(sda_out));
  // R10
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> $rose(cs_n));
  // R11
  chain_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cs_n) |-> (sclk && sda_oe && !req_read));
endmodule

bind nine_bit_spi_link nine_bit_spi_link_chk u_chk (.*);

// File: tb/sim_nine_bit_spi_link.sv
`timescale 1ns/1ps
module sim_nine_bit_spi_link;
  localparam int HD = 3;
  localparam logic [8:0] WR_VEC [4] = '{9'h011, 9'h1A5, 9'h0FF, 9'h100};

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_read = 0, req_is_data = 0, sda_in = 0;
  logic [7:0] req_byte = 0;
  logic [2:0] req_rlen = 0;
  logic req_ready, sclk, cs_n, sda_out, sda_oe, busy, rd_done, rd_err;
  logic [31:0] rd_data;

  always #5 clk = ~clk;

  nine_bit_spi_link #(.HALF_DIV(HD)) u0 (.*);

  int checks = 0, fails = 0;
  int cyc = 0, t_csf = 0, t_rise = 0, t_fall = 0;
  int cs_falls = 0, tx_cnt = 0, rx_rises = 0, fall_cnt = 0, done_cnt = 0, err_cnt = 0;
  int cs_err = 0, per_err = 0, hold_err = 0;
  logic prev_cs = 1, prev_sclk = 0, first_pend = 0, have_rise = 0, rise_val = 0, acc_cs = 0;
  logic [63:0] tx_log = 0;
  logic [8:0] rxw [4];

  function automatic logic rx_bit(input int k);
    return rxw[k / 9][8 - (k % 9)];
  endfunction

  function automatic logic [31:0] exp_rd(input int n);
    logic [31:0] r = 0;
    int c = 0;
    for (int i = 0; i < n; i++) begin
      int t = (int'(rxw[i]) >> i) | (c << (9 - i));
      r[8*i +: 8] = t[7:0];
      c = int'(rxw[i]) & ((1 << i) - 1);
    end
    return r;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_cs && !cs_n) begin t_csf = cyc; cs_falls++; first_pend = 1; have_rise = 0; end
      if (!prev_sclk && sclk) begin
        if (first_pend) begin if (cyc - t_csf != HD) cs_err++; first_pend = 0; end
        else if (have_rise && (cyc - t_rise != 2 * HD)) per_err++;
        have_rise = 1; t_rise = cyc;
        if (sda_oe) begin tx_log = {tx_log[62:0], sda_out}; tx_cnt++; end
        else rx_rises++;
        rise_val = sda_out;
      end
      if (prev_sclk && sclk && sda_oe && sda_out != rise_val) hold_err++;
      if (prev_sclk && !sclk) begin t_fall = cyc; if (!sda_oe && !cs_n) fall_cnt++; end
      if (!prev_cs && cs_n) begin if (cyc - t_fall != HD) cs_err++; fall_cnt = 0; end
      if (rd_done) done_cnt++;
      if (rd_err) err_cnt++;
      sda_in = (fall_cnt == 0) ? 1'b0 : rx_bit(fall_cnt - 1);
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic rd, input logic dat, input logic [7:0] b, input logic [2:0] len);
    @(negedge clk);
    req_valid = 1; req_read = rd; req_is_data = dat; req_byte = b; req_rlen = len;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    acc_cs = cs_n;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!cs_n);
    @(negedge clk); #1;
  endtask

  initial begin
    int n_tx, n_rx, n_cs, n_done, n_err;
    logic [31:0] snap;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk(cs_n && !sclk && !sda_oe && !busy && req_ready && !rd_done && !rd_err && rd_data == 0,
        "R1 idle", {cs_n, sclk, sda_oe, busy, req_ready, rd_done, rd_err, rd_data},
        {7'b1000100, 32'h0});

    // R2 write frames from the vector table
    for (int i = 0; i < 4; i++) begin
      n_tx = tx_cnt;
      send(0, WR_VEC[i][8], WR_VEC[i][7:0], 0);
      if (i == 0) begin
        @(negedge clk); #1;
        chk(busy == 1, "R5 busy after accept", busy, 1);
      end
      wait_idle();
      chk(tx_cnt - n_tx == 9 && tx_log[8:0] == WR_VEC[i], "R2 write frame",
          {tx_cnt - n_tx, tx_log[8:0]}, {9, WR_VEC[i]});
    end
    chk(busy == 0, "R5 busy after release", busy, 0);

    // R6 chained writes under one chip select
    n_tx = tx_cnt; n_cs = cs_falls;
    send(0, 0, 8'h2C, 0);
    send(0, 1, 8'hC3, 0);
    wait_idle();
    chk(tx_cnt - n_tx == 18 && tx_log[17:0] == {9'h02C, 9'h1C3}, "R6 chain bits",
        tx_log[17:0], {9'h02C, 9'h1C3});
    chk(cs_falls - n_cs == 1, "R6 single select", cs_falls - n_cs, 1);

    // R7 R9 R10 identification read
    rxw[0] = 9'h085; rxw[1] = 9'h10A; rxw[2] = 9'h148; rxw[3] = 9'h000;
    n_tx = tx_cnt; n_rx = rx_rises; n_cs = cs_falls; n_done = done_cnt;
    send(1, 1, 8'h04, 3);
    wait_idle();
    chk(tx_cnt - n_tx == 9 && tx_log[8:0] == 9'h004, "R7 read command frame", tx_log[8:0], 9'h004);
    chk(rx_rises - n_rx == 27 && cs_falls - n_cs == 1, "R7 receive clocks",
        rx_rises - n_rx, 27);
    chk(rd_data == exp_rd(3), "R9 realign 3 bytes", rd_data, exp_rd(3));
    chk(rd_data[23:0] == 24'h528585 && done_cnt - n_done == 1, "R10 id bytes and done",
        rd_data[23:0], 24'h528585);

    // R9 four-byte read
    rxw[0] = 9'h1F3; rxw[1] = 9'h0A7; rxw[2] = 9'h16D; rxw[3] = 9'h13C;
    n_rx = rx_rises; n_done = done_cnt;
    send(1, 0, 8'hDA, 4);
    wait_idle();
    chk(rd_data == exp_rd(4) && rx_rises - n_rx == 36, "R9 realign 4 bytes", rd_data, exp_rd(4));
    chk(done_cnt - n_done == 1, "R10 done pulse 4", done_cnt - n_done, 1);

    // R9 one-byte read
    rxw[0] = 9'h1C8;
    send(1, 0, 8'h0A, 1);
    wait_idle();
    chk(rd_data == 32'h0000_00C8, "R9 realign 1 byte", rd_data, 32'hC8);

    // R8 rejected lengths
    for (int k = 0; k < 3; k++) begin
      logic [2:0] bad;
      bad = (k == 0) ? 3'd2 : (k == 1) ? 3'd0 : 3'd5;
      snap = rd_data; n_cs = cs_falls; n_err = err_cnt; n_done = done_cnt;
      send(1, 0, 8'h04, bad);
      repeat (2 * HD + 2) @(negedge clk);
      #1;
      chk(err_cnt - n_err == 1 && cs_falls == n_cs && rd_data == snap && done_cnt == n_done,
          "R8 rejected length", {err_cnt - n_err, cs_falls - n_cs}, {32'd1, 32'd0});
    end

    // R11 read held off from the chaining window
    rxw[0] = 9'h055;
    n_cs = cs_falls; n_tx = tx_cnt;
    send(0, 0, 8'h2A, 0);
    send(1, 0, 8'h0B, 1);
    chk(acc_cs == 1, "R11 read taken only when idle", acc_cs, 1);
    wait_idle();
    chk(cs_falls - n_cs == 2 && tx_cnt - n_tx == 18 && rd_data == 32'h55, "R11 separate selects",
        cs_falls - n_cs, 2);

    chk(cs_err == 0, "R3 select edges", cs_err, 0);
    chk(per_err == 0, "R4 sclk period", per_err, 0);
    chk(hold_err == 0, "R2 data held while high", hold_err, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
    $finish;
  end
endmodule